// File: doc/BRIEF.md
# Big-endian load/store alignment unit

This unit sits between a 32-bit register datapath and a data memory that is addressed by byte but organised as 32-bit words. For each request it adds a sign-extended 16-bit displacement to a base register value to form the effective address. It drives a word-aligned memory address and, for stores, per-lane write enables and lane-placed write data. For loads it takes the word returned by memory, picks the addressed byte or halfword in big-endian lane order and widens it to 32 bits with sign or zero fill. It also produces the upper-immediate constant, flags accesses that are not naturally aligned, and keeps one link reservation for the linked-load / conditional-store pair.

The address, enable, data and result paths are combinational within the request cycle. The memory is expected to return `rd_word` in the same cycle that `mem_rd` is high. Only the reservation is registered. A small state machine holds it, with two states: `RSV_IDLE` (no reservation) and `RSV_HELD` (a reservation is held, together with its word tag). The named transitions are as follows. LINK goes from `RSV_IDLE` to `RSV_HELD` on an aligned linked load. RELINK stays in `RSV_HELD` on a further aligned linked load and replaces the tag. HIT_STORE goes from `RSV_HELD` to `RSV_IDLE` on a plain store that writes the tagged word. COND goes from `RSV_HELD` to `RSV_IDLE` on any accepted conditional store. In every other case the state holds, and a store to a different word does not change it.

Top module: `be_lsu`

## Requirements
- R1: `mem_addr` equals `base_val` plus the sign-extended `disp`, with bits 1:0 forced to zero.
- R2: Operation codes on `op`: 0 word load, 1 signed half load, 2 unsigned half load, 3 signed byte load, 4 unsigned byte load, 5 word store, 6 half store, 7 byte store, 8 upper immediate, 9 linked load, 10 conditional store. All other codes, and any code while `req_valid` is 0, drive no read, no write, enables 0000, result 0, and misalign flag 0. They also leave the reservation unchanged.
- R3: Byte offset k (effective address bits 1:0) maps to data bits 31-8k down to 24-8k and to enable bit 3-k. A byte store enables one lane and carries `st_val[7:0]` there. A half store at offset 0 enables 1100 and at offset 2 enables 0011, and carries `st_val[15:0]` in that lane pair. A word store enables 1111 and carries `st_val`.
- R4: A byte load returns the addressed lane, sign-extended for code 3 and zero-extended for code 4.
- R5: A half load returns the addressed lane pair with the upper 16 bits filled from its bit 15 (code 1) or with zeros (code 2).
- R6: A word load and a linked load return `rd_word` unchanged and raise `mem_rd`.
- R7: Upper immediate returns `{disp, 16'h0000}` with neither `mem_rd` nor `mem_wr` raised.
- R8: A half access with address bit 0 set, or a word, linked or conditional access with either of bits 1:0 set, raises `misalign`. It raises neither `mem_rd` nor `mem_wr`, sets the enables to 0000 and returns 0.
- R9: After reset no reservation is held. An aligned linked load sets the reservation to its word, replacing any earlier one, from the next cycle.
- R10: A plain store that writes the reserved word clears the reservation. A store to any other word leaves it in place.
- R11: A conditional store writes the full word and returns 1 only if the reservation is held for its word. Otherwise it returns 0 and does not write. In every case the reservation is cleared from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code (see R2) |
| base_val | input | 32 | Base register value |
| disp | input | 16 | Signed displacement, also the upper-immediate value |
| st_val | input | 32 | Source register value for stores |
| rd_word | input | 32 | Word returned by memory |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_be | output | 4 | Lane write enables, bit 3 for offset 0 |
| mem_wdata | output | 32 | Lane-placed write data |
| result | output | 32 | Value for the destination register |
| misalign | output | 1 | Misaligned access flag |

## Verification
The only stored state is the reservation flag and its word tag. A wrong flag or tag does not appear at the ports when it is written. It appears at the next conditional store, which writes when it should not or fails when it should succeed, and `mem_wr` and `result` show this in that same cycle. For this reason, every sequence that could corrupt the reservation is followed directly by a conditional store to the tagged word. The lane mapping is combinational, so a swapped lane shows in `mem_be`, `mem_wdata` or `result` in the request cycle itself.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [3:0] {
        OP_LW  = 4'd0,
        OP_LH  = 4'd1,
        OP_LHU = 4'd2,
        OP_LB  = 4'd3,
        OP_LBU = 4'd4,
        OP_SW  = 4'd5,
        OP_SH  = 4'd6,
        OP_SB  = 4'd7,
        OP_LUI = 4'd8,
        OP_LL  = 4'd9,
        OP_SC  = 4'd10
    } lsu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } lsu_size_e;

    typedef enum logic {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic        req_valid,
    input  logic [3:0]  op,
    input  logic [1:0]  ea_low,
    output logic        is_load,
    output logic        is_store,
    output logic        is_ll,
    output logic        is_sc,
    output logic        is_lui,
    output lsu_size_e   size,
    output logic        sign_ext,
    output logic        misalign
);
    logic touches_mem;

    always_comb begin
        is_load  = 1'b0;
        is_store = 1'b0;
        is_ll    = 1'b0;
        is_sc    = 1'b0;
        is_lui   = 1'b0;
        size     = SZ_WORD;
        sign_ext = 1'b0;
        if (req_valid) begin
            unique case (op)
                OP_LW:   begin is_load = 1'b1; end
                OP_LH:   begin is_load = 1'b1; size = SZ_HALF; sign_ext = 1'b1; end
                OP_LHU:  begin is_load = 1'b1; size = SZ_HALF; end
                OP_LB:   begin is_load = 1'b1; size = SZ_BYTE; sign_ext = 1'b1; end
                OP_LBU:  begin is_load = 1'b1; size = SZ_BYTE; end
                OP_SW:   begin is_store = 1'b1; end
                OP_SH:   begin is_store = 1'b1; size = SZ_HALF; end
                OP_SB:   begin is_store = 1'b1; size = SZ_BYTE; end
                OP_LUI:  begin is_lui = 1'b1; end
                OP_LL:   begin is_load = 1'b1; is_ll = 1'b1; end
                OP_SC:   begin is_sc = 1'b1; end
                default: begin end
            endcase
        end
    end

    assign touches_mem = is_load | is_store | is_sc;

    always_comb begin
        unique case (size)
            SZ_HALF: misalign = touches_mem & ea_low[0];
            SZ_WORD: misalign = touches_mem & (ea_low != 2'b00);
            default: misalign = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  lsu_size_e                 size,
    input  logic [$clog2(XLEN/8)-1:0] off,
    input  logic [XLEN-1:0]           src,
    output logic [XLEN/8-1:0]         be_raw,
    output logic [XLEN-1:0]           wdata
);
    localparam int LANES = XLEN / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic byte_hit;
        logic half_hit;
        assign byte_hit = (off == i);
        assign half_hit = (off[1] == i[1]);
        always_comb begin
            unique case (size)
                SZ_BYTE: be_raw[LANES-1-i] = byte_hit;
                SZ_HALF: be_raw[LANES-1-i] = half_hit;
                default: be_raw[LANES-1-i] = 1'b1;
            endcase
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: wdata = {LANES{src[7:0]}};
            SZ_HALF: wdata = {(LANES/2){src[15:0]}};
            default: wdata = src;
        endcase
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  lsu_size_e                 size,
    input  logic                      sign_ext,
    input  logic [$clog2(XLEN/8)-1:0] off,
    input  logic [XLEN-1:0]           rdata,
    output logic [XLEN-1:0]           dout
);
    localparam int LANES = XLEN / 8;
    localparam int OFFW  = $clog2(LANES);

    logic [7:0]  lane [LANES];
    logic [7:0]  pick_b;
    logic [15:0] pick_h;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = rdata[XLEN-1-8*i -: 8];
    end

    assign pick_b = lane[off];
    assign pick_h = {lane[{off[OFFW-1:1], 1'b0}], lane[{off[OFFW-1:1], 1'b1}]};

    always_comb begin
        unique case (size)
            SZ_BYTE: dout = {{(XLEN-8){sign_ext & pick_b[7]}}, pick_b};
            SZ_HALF: dout = {{(XLEN-16){sign_ext & pick_h[15]}}, pick_h};
            default: dout = rdata;
        endcase
    end

endmodule

// File: rtl/lsu_rsv_fsm.sv
module lsu_rsv_fsm
    import lsu_pkg::*;
#(
    parameter int TAGW = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_go,
    input  logic            store_go,
    input  logic            cond_go,
    input  logic [TAGW-1:0] word_tag,
    output logic            held,
    output logic            tag_match
);
    rsv_state_e      state_q, state_d;
    logic [TAGW-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_IDLE;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (link_go) tag_q <= word_tag;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_IDLE: if (link_go) state_d = RSV_HELD;
            RSV_HELD: begin
                if (link_go)                     state_d = RSV_HELD;
                else if (cond_go)                state_d = RSV_IDLE;
                else if (store_go && tag_match)  state_d = RSV_IDLE;
            end
            default: state_d = RSV_IDLE;
        endcase
    end

    assign held      = (state_q == RSV_HELD);
    assign tag_match = held && (tag_q == word_tag);

endmodule

// File: rtl/be_lsu.sv
module be_lsu
    import lsu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        op,
    input  logic [XLEN-1:0]   base_val,
    input  logic [IMMW-1:0]   disp,
    input  logic [XLEN-1:0]   st_val,
    input  logic [XLEN-1:0]   rd_word,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [XLEN-1:0]   result,
    output logic              misalign
);
    localparam int LANES = XLEN / 8;
    localparam int OFFW  = $clog2(LANES);
    localparam int TAGW  = XLEN - OFFW;

    logic [XLEN-1:0]  ea;
    logic             is_load, is_store, is_ll, is_sc, is_lui;
    lsu_size_e        size;
    logic             sign_ext;
    logic             mis;
    logic [LANES-1:0] be_raw;
    logic [XLEN-1:0]  wdata_raw;
    logic [XLEN-1:0]  load_val;
    logic             resv_held;
    logic             tag_match;
    logic             sc_ok;
    logic             plain_wr;

    assign ea = base_val + {{(XLEN-IMMW){disp[IMMW-1]}}, disp};

    lsu_decode u_dec (
        .req_valid (req_valid),
        .op        (op),
        .ea_low    (ea[1:0]),
        .is_load   (is_load),
        .is_store  (is_store),
        .is_ll     (is_ll),
        .is_sc     (is_sc),
        .is_lui    (is_lui),
        .size      (size),
        .sign_ext  (sign_ext),
        .misalign  (mis)
    );

    lsu_store_lane #(.XLEN(XLEN)) u_st (
        .size   (size),
        .off    (ea[OFFW-1:0]),
        .src    (st_val),
        .be_raw (be_raw),
        .wdata  (wdata_raw)
    );

    lsu_load_extract #(.XLEN(XLEN)) u_ld (
        .size     (size),
        .sign_ext (sign_ext),
        .off      (ea[OFFW-1:0]),
        .rdata    (rd_word),
        .dout     (load_val)
    );

    assign plain_wr = is_store & ~mis;
    assign sc_ok    = is_sc & ~mis & tag_match;

    lsu_rsv_fsm #(.TAGW(TAGW)) u_rsv (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_go   (is_ll & ~mis),
        .store_go  (plain_wr),
        .cond_go   (is_sc),
        .word_tag  (ea[XLEN-1:OFFW]),
        .held      (resv_held),
        .tag_match (tag_match)
    );

    always_comb begin
        mem_addr  = {ea[XLEN-1:OFFW], {OFFW{1'b0}}};
        mem_rd    = is_load & ~mis;
        mem_wr    = plain_wr | sc_ok;
        mem_be    = mem_wr ? be_raw : '0;
        mem_wdata = wdata_raw;
        misalign  = mis;
        if (is_lui)
            result = {disp, {(XLEN-IMMW){1'b0}}};
        else if (is_sc)
            result = {{(XLEN-1){1'b0}}, sc_ok};
        else if (is_load && !mis)
            result = load_val;
        else
            result = '0;
    end

endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk #(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        op,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [XLEN/8-1:0] mem_be,
    input logic              misalign,
    input logic [XLEN-1:0]   result,
    input logic              resv_held
);
    logic is_sc_req;
    logic is_ll_req;
    assign is_sc_req = req_valid && (op == 4'd10);
    assign is_ll_req = req_valid && (op == 4'd9);

    a_r8_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_wr && !mem_rd && mem_be == '0));

    a_r3_be_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr |-> (mem_be == '0));

    a_r3_be_width: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                    || $countones(mem_be) == 4));

    a_r9_link_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ll_req && !misalign) |=> resv_held);

    a_r11_cond_clears: assert property (@(posedge clk) disable iff (!rst_n)
        is_sc_req |=> !resv_held);

    a_r11_cond_needs_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc_req && mem_wr) |-> (resv_held && result == 1));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_wr && !mem_rd && !misalign && result == '0));

endmodule

bind be_lsu be_lsu_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op        (op),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_be    (mem_be),
    .misalign  (misalign),
    .result    (result),
    .resv_held (resv_held)
);

// File: tb/be_lsu_test.sv
`timescale 1ns/1ps
module be_lsu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] base_val = '0;
    logic [15:0] disp = '0;
    logic [31:0] st_val = '0;
    logic [31:0] rd_word = '0;
    logic [31:0] mem_addr;
    logic        mem_rd, mem_wr, misalign;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    be_lsu uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .base_val(base_val), .disp(disp), .st_val(st_val), .rd_word(rd_word),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .result(result), .misalign(misalign)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] o, input logic [31:0] b, input logic [15:0] d,
                         input logic [31:0] s, input logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; op = o; base_val = b; disp = d; st_val = s; rd_word = r;
        #1;
    endtask

    task automatic quiet;
        @(negedge clk);
        req_valid = 1'b0; op = 4'd0;
        #1;
    endtask

    task automatic t_reset;
        check("R9 reset rd", {31'b0, mem_rd}, 0);
        issue(4'd10, 32'h3000, 16'h0, 32'h55, 0);
        check("R9 sc after reset result", result, 0);
        check("R9 sc after reset wr", {31'b0, mem_wr}, 0);
        quiet();
    endtask

    task automatic t_addr;
        issue(4'd0, 32'h1000, 16'hFFFC, 0, 32'hCAFEF00D);
        check("R1 negative disp addr", mem_addr, 32'h0FFC);
        check("R6 word load", result, 32'hCAFEF00D);
        check("R6 word load rd", {31'b0, mem_rd}, 1);
        issue(4'd4, 32'h2000, 16'h0005, 0, 0);
        check("R1 positive disp addr", mem_addr, 32'h2004);
        quiet();
    endtask

    task automatic t_stores;
        issue(4'd7, 32'h2000, 16'h1, 32'hA1B2C3D4, 0);
        check("R3 sb off1 be", {28'b0, mem_be}, 32'h4);
        check("R3 sb off1 lane", {24'b0, mem_wdata[23:16]}, 32'hD4);
        issue(4'd7, 32'h2000, 16'h3, 32'hA1B2C3D4, 0);
        check("R3 sb off3 be", {28'b0, mem_be}, 32'h1);
        check("R3 sb off3 lane", {24'b0, mem_wdata[7:0]}, 32'hD4);
        issue(4'd6, 32'h2000, 16'h0, 32'hA1B2C3D4, 0);
        check("R3 sh off0 be", {28'b0, mem_be}, 32'hC);
        check("R3 sh off0 lane", {16'b0, mem_wdata[31:16]}, 32'hC3D4);
        issue(4'd6, 32'h2000, 16'h2, 32'hA1B2C3D4, 0);
        check("R3 sh off2 be", {28'b0, mem_be}, 32'h3);
        check("R3 sh off2 lane", {16'b0, mem_wdata[15:0]}, 32'hC3D4);
        issue(4'd5, 32'h2000, 16'h0, 32'hA1B2C3D4, 0);
        check("R3 sw be", {28'b0, mem_be}, 32'hF);
        check("R3 sw data", mem_wdata, 32'hA1B2C3D4);
        check("R3 sw wr", {31'b0, mem_wr}, 1);
        quiet();
    endtask

    task automatic t_loads;
        logic [31:0] w;
        w = 32'h817FC324;
        issue(4'd3, 32'h2000, 16'h0, 0, w); check("R4 lb off0", result, 32'hFFFFFF81);
        issue(4'd4, 32'h2000, 16'h0, 0, w); check("R4 lbu off0", result, 32'h00000081);
        issue(4'd3, 32'h2000, 16'h1, 0, w); check("R4 lb off1", result, 32'h0000007F);
        issue(4'd3, 32'h2000, 16'h2, 0, w); check("R4 lb off2", result, 32'hFFFFFFC3);
        issue(4'd4, 32'h2000, 16'h3, 0, w); check("R4 lbu off3", result, 32'h00000024);
        issue(4'd1, 32'h2000, 16'h0, 0, w); check("R5 lh off0", result, 32'hFFFF817F);
        issue(4'd2, 32'h2000, 16'h0, 0, w); check("R5 lhu off0", result, 32'h0000817F);
        issue(4'd1, 32'h2000, 16'h2, 0, w); check("R5 lh off2", result, 32'hFFFFC324);
        issue(4'd2, 32'h2000, 16'h2, 0, w); check("R5 lhu off2", result, 32'h0000C324);
        check("R5 load no write", {31'b0, mem_wr}, 0);
        quiet();
    endtask

    task automatic t_lui;
        issue(4'd8, 32'h1234, 16'hBEEF, 0, 32'hFFFFFFFF);
        check("R7 lui value", result, 32'hBEEF0000);
        check("R7 lui no access", {30'b0, mem_rd, mem_wr}, 0);
        quiet();
    endtask

    task automatic t_misalign;
        issue(4'd0, 32'h2000, 16'h2, 0, 32'h11223344);
        check("R8 lw off2 flag", {31'b0, misalign}, 1);
        check("R8 lw off2 quiet", {mem_be, 26'b0, mem_rd, mem_wr}, 0);
        check("R8 lw off2 result", result, 0);
        issue(4'd6, 32'h2000, 16'h1, 32'hFFFF, 0);
        check("R8 sh off1 flag", {31'b0, misalign}, 1);
        check("R8 sh off1 no write", {mem_be, 27'b0, mem_wr}, 0);
        issue(4'd1, 32'h2000, 16'h3, 0, 0);
        check("R8 lh off3 flag", {31'b0, misalign}, 1);
        issue(4'd7, 32'h2000, 16'h3, 32'h5A, 0);
        check("R8 sb off3 aligned", {31'b0, misalign}, 0);
        quiet();
    endtask

    task automatic t_invalid;
        @(negedge clk);
        req_valid = 1'b0; op = 4'd5; base_val = 32'h2000; disp = 0; st_val = 32'hFFFFFFFF;
        #1;
        check("R2 idle store quiet", {mem_be, 26'b0, mem_rd, mem_wr}, 0);
        issue(4'hF, 32'h2003, 16'h0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R2 unknown op quiet", {mem_be, 25'b0, misalign, mem_rd, mem_wr}, 0);
        check("R2 unknown op result", result, 0);
        quiet();
    endtask

    task automatic t_link_basic;
        issue(4'd9, 32'h3000, 16'h0, 0, 32'h12345678);
        check("R6 ll value", result, 32'h12345678);
        check("R6 ll rd", {31'b0, mem_rd}, 1);
        issue(4'd10, 32'h3000, 16'h0, 32'h55, 0);
        check("R11 sc success result", result, 1);
        check("R11 sc success write", {27'b0, mem_be, mem_wr}, 32'h1F);
        check("R11 sc data", mem_wdata, 32'h55);
        issue(4'd10, 32'h3000, 16'h0, 32'h66, 0);
        check("R11 second sc fails", {result[30:0], mem_wr}, 0);
        quiet();
    endtask

    task automatic t_link_other;
        issue(4'd9, 32'h3000, 16'h0, 0, 0);
        issue(4'd10, 32'h3004, 16'h0, 32'h1, 0);
        check("R11 sc other word fails", {result[30:0], mem_wr}, 0);
        issue(4'd10, 32'h3000, 16'h0, 32'h1, 0);
        check("R11 cleared after failed sc", {result[30:0], mem_wr}, 0);
        issue(4'd9, 32'h3000, 16'h0, 0, 0);
        issue(4'd10, 32'h3002, 16'h0, 32'h1, 0);
        check("R8 misaligned sc flag", {misalign, result[30:0]}, 32'h80000000);
        issue(4'd10, 32'h3000, 16'h0, 32'h1, 0);
        check("R11 cleared after misaligned sc", {result[30:0], mem_wr}, 0);
        quiet();
    endtask

    task automatic t_link_store;
        issue(4'd9, 32'h3000, 16'h0, 0, 0);
        issue(4'd7, 32'h3000, 16'h2, 32'h9, 0);
        issue(4'd10, 32'h3000, 16'h0, 32'h1, 0);
        check("R10 byte store in word clears", {result[30:0], mem_wr}, 0);
        issue(4'd9, 32'h3000, 16'h0, 0, 0);
        issue(4'd5, 32'h3008, 16'h0, 32'h9, 0);
        issue(4'd10, 32'h3000, 16'h0, 32'h1, 0);
        check("R10 store elsewhere keeps", {result[30:0], mem_wr}, 32'h3);
        issue(4'd9, 32'h3000, 16'h0, 0, 0);
        issue(4'd9, 32'h4000, 16'h0, 0, 0);
        issue(4'd10, 32'h3000, 16'h0, 32'h1, 0);
        check("R9 relink drops old word", {result[30:0], mem_wr}, 0);
        issue(4'd9, 32'h3000, 16'h0, 0, 0);
        issue(4'd9, 32'h4000, 16'h0, 0, 0);
        issue(4'd10, 32'h4000, 16'h0, 32'h1, 0);
        check("R9 relink new word", {result[30:0], mem_wr}, 32'h3);
        issue(4'd9, 32'h3000, 16'h0, 0, 0);
        @(negedge clk);
        req_valid = 1'b0; op = 4'd10; base_val = 32'h3000;
        #1;
        issue(4'hE, 32'h3000, 16'h0, 0, 0);
        issue(4'd10, 32'h3000, 16'h0, 32'h1, 0);
        check("R2 idle and unknown keep rsv", {result[30:0], mem_wr}, 32'h3);
        quiet();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_addr();
        t_stores();
        t_loads();
        t_lui();
        t_misalign();
        t_invalid();
        t_link_basic();
        t_link_other();
        t_link_store();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule